// File: doc/BRIEF.md
# Backup Supply Switchover Controller

This block decides whether a real-time clock is powered from its main supply or from its backup battery. Each clock cycle it registers the digitized main-supply and battery voltages, both given as millivolt codes, together with a low-power-mode select. It then compares these registered samples against the rules for entering and leaving battery operation. While battery operation is active, the serial bus is turned off, and its write port has no effect on the block.

The block stamps every switchover with the packed time and date supplied at its input. It keeps two stamp banks, and they follow opposite rules. The power-down bank (main to battery) keeps the first event, and is refilled only after software has cleared it. The power-up bank (battery to main) is overwritten on every return to main power. Software clears a bank one byte at a time, by writing 00h to that byte.

Top module: `bkup_switch_ctrl`

## Requirements
- R1: After reset the block is in main-supply mode: on_battery is 0, bus_en is 1, and both stamp banks read zero.
- R2: With low_pwr=0, main-supply mode is left only when both of these hold on the sampled codes: vdd+50 < vbat, and vdd < 2200.
- R3: With low_pwr=0, battery mode is left when either of these holds: vdd > vbat+50, or vdd > 2230.
- R4: With low_pwr=1, the 2200/2230 trip comparisons are ignored. The block enters battery mode when vdd+50 < vbat, and leaves it only when vdd > vbat+50.
- R5: bus_en is always the inverse of on_battery.
- R6: On a switch into battery mode, now_time is copied into v2b_stamp only if all five bytes of v2b_stamp are zero. Otherwise the earlier stamp is kept.
- R7: On a switch back to main mode, now_time is always copied into b2v_stamp.
- R8: A write with wr_en=1 and wr_data=00h clears byte wr_idx of the bank selected by wr_bank (0 selects v2b, 1 selects b2v). Byte 0 is bits 7:0 (minute), and bytes 1 to 4 hold hour, date, month and year in ascending bit order. A nonzero wr_data, or a wr_idx of 5 or more, leaves the bank unchanged.
- R9: Writes are ignored while on_battery is 1.
- R10: An input change first affects on_battery at the second rising clock edge after it is applied. The stamps are updated at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vdd_mv | input | 13 | Main supply voltage code in mV |
| vbat_mv | input | 13 | Battery voltage code in mV |
| low_pwr | input | 1 | Selects low-power switching rules |
| now_time | input | 40 | Current packed time/date, five bytes |
| wr_en | input | 1 | Stamp byte write strobe |
| wr_bank | input | 1 | 0 selects v2b bank, 1 selects b2v bank |
| wr_idx | input | 3 | Byte index within the bank |
| wr_data | input | 8 | Write data; only 00h has an effect |
| on_battery | output | 1 | Battery mode is active |
| bus_en | output | 1 | Serial bus enable |
| v2b_stamp | output | 40 | Stamp of the first main-to-battery switch |
| b2v_stamp | output | 40 | Stamp of the latest battery-to-main switch |

## Verification
The assertions assume that now_time and the write port are driven with defined values, and that no write reaches the power-down bank in the same cycle as a switch into battery mode. The stimulus changes its inputs only on falling edges, and it leaves at least two edges between a voltage step and a write. The voltage sweeps keep their codes inside the 13-bit range, and they step vdd to just below, exactly at, and just above each threshold.

// File: rtl/bkup_pkg.sv
package bkup_pkg;
    localparam int STAMP_BYTES = 5;
    localparam int STAMP_W     = STAMP_BYTES * 8;

    typedef logic [STAMP_BYTES-1:0][7:0] stamp_t;

    typedef enum logic {
        PWR_MAIN = 1'b0,
        PWR_BATT = 1'b1
    } pwr_mode_e;
endpackage

// File: rtl/supply_sample.sv
module supply_sample #(
    parameter int VW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] vdd_i,
    input  logic [VW-1:0] vbat_i,
    input  logic          lp_i,
    output logic [VW-1:0] vdd_o,
    output logic [VW-1:0] vbat_o,
    output logic          lp_o
);
    typedef struct packed {
        logic [VW-1:0] vdd;
        logic [VW-1:0] vbat;
        logic          lp;
    } samp_t;

    samp_t samp_d, samp_q;

    always_comb begin
        samp_d      = samp_q;
        samp_d.vdd  = vdd_i;
        samp_d.vbat = vbat_i;
        samp_d.lp   = lp_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q.vdd  <= '1;
            samp_q.vbat <= '0;
            samp_q.lp   <= 1'b0;
        end else begin
            samp_q <= samp_d;
        end
    end

    assign vdd_o  = samp_q.vdd;
    assign vbat_o = samp_q.vbat;
    assign lp_o   = samp_q.lp;
endmodule

// File: rtl/switch_fsm.sv
module switch_fsm
    import bkup_pkg::*;
#(
    parameter int VW       = 13,
    parameter int HYS_BAT  = 50,
    parameter int TRIP_MV  = 2200,
    parameter int HYS_TRIP = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] vdd_s,
    input  logic [VW-1:0] vbat_s,
    input  logic          lp_s,
    output pwr_mode_e     mode_o,
    output logic          go_batt_o,
    output logic          go_main_o
);
    localparam int WW = VW + 2;
    localparam logic [WW-1:0] HB  = WW'(HYS_BAT);
    localparam logic [WW-1:0] TLO = WW'(TRIP_MV);
    localparam logic [WW-1:0] THI = WW'(TRIP_MV + HYS_TRIP);

    typedef struct packed {
        pwr_mode_e mode;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic [WW-1:0] vdd_w, vbat_w;
    logic below_bat, above_bat, below_trip, above_trip;
    logic want_batt, want_main;

    always_comb begin
        vdd_w      = WW'(vdd_s);
        vbat_w     = WW'(vbat_s);
        below_bat  = (vdd_w + HB) < vbat_w;
        above_bat  = vdd_w > (vbat_w + HB);
        below_trip = vdd_w < TLO;
        above_trip = vdd_w > THI;
        if (lp_s) begin
            want_batt = below_bat;
            want_main = above_bat;
        end else begin
            want_batt = below_bat && below_trip;
            want_main = above_bat || above_trip;
        end
        fsm_d     = fsm_q;
        go_batt_o = 1'b0;
        go_main_o = 1'b0;
        case (fsm_q.mode)
            PWR_MAIN: if (want_batt) begin
                fsm_d.mode = PWR_BATT;
                go_batt_o  = 1'b1;
            end
            PWR_BATT: if (want_main) begin
                fsm_d.mode = PWR_MAIN;
                go_main_o  = 1'b1;
            end
            default: fsm_d.mode = PWR_MAIN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q.mode <= PWR_MAIN;
        else        fsm_q      <= fsm_d;
    end

    assign mode_o = fsm_q.mode;
endmodule

// File: rtl/stamp_bank.sv
module stamp_bank
    import bkup_pkg::*;
#(
    parameter bit KEEP_FIRST = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       capture_i,
    input  stamp_t     time_i,
    input  logic       wr_hit_i,
    input  logic [2:0] wr_idx_i,
    input  logic [7:0] wr_data_i,
    output stamp_t     stamp_o
);
    typedef struct packed {
        stamp_t bytes;
    } bank_t;

    bank_t bank_d, bank_q;
    logic  empty;

    always_comb begin
        bank_d = bank_q;
        empty  = (bank_q.bytes == '0);
        if (wr_hit_i && (wr_data_i == 8'h00) && (int'(wr_idx_i) < STAMP_BYTES))
            bank_d.bytes[wr_idx_i] = 8'h00;
        if (capture_i && (!KEEP_FIRST || empty))
            bank_d.bytes = time_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign stamp_o = bank_q.bytes;
endmodule

// File: rtl/bkup_switch_ctrl.sv
module bkup_switch_ctrl
    import bkup_pkg::*;
#(
    parameter int VW       = 13,
    parameter int HYS_BAT  = 50,
    parameter int TRIP_MV  = 2200,
    parameter int HYS_TRIP = 30
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VW-1:0]      vdd_mv,
    input  logic [VW-1:0]      vbat_mv,
    input  logic               low_pwr,
    input  logic [STAMP_W-1:0] now_time,
    input  logic               wr_en,
    input  logic               wr_bank,
    input  logic [2:0]         wr_idx,
    input  logic [7:0]         wr_data,
    output logic               on_battery,
    output logic               bus_en,
    output logic [STAMP_W-1:0] v2b_stamp,
    output logic [STAMP_W-1:0] b2v_stamp
);
    logic [VW-1:0] vdd_s, vbat_s;
    logic          lp_s;
    pwr_mode_e     mode;
    logic          go_batt, go_main;
    stamp_t        stamps [2];

    supply_sample #(.VW(VW)) u_samp (
        .clk(clk), .rst_n(rst_n),
        .vdd_i(vdd_mv), .vbat_i(vbat_mv), .lp_i(low_pwr),
        .vdd_o(vdd_s), .vbat_o(vbat_s), .lp_o(lp_s)
    );

    switch_fsm #(
        .VW(VW), .HYS_BAT(HYS_BAT), .TRIP_MV(TRIP_MV), .HYS_TRIP(HYS_TRIP)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .vdd_s(vdd_s), .vbat_s(vbat_s), .lp_s(lp_s),
        .mode_o(mode), .go_batt_o(go_batt), .go_main_o(go_main)
    );

    // bank 0 keeps the first power-down, bank 1 the latest power-up
    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic hit;
        assign hit = wr_en && (mode == PWR_MAIN) && (wr_bank == 1'(g));
        stamp_bank #(.KEEP_FIRST(g == 0)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .capture_i((g == 0) ? go_batt : go_main),
            .time_i(stamp_t'(now_time)),
            .wr_hit_i(hit), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
            .stamp_o(stamps[g])
        );
    end

    assign on_battery = (mode == PWR_BATT);
    assign bus_en     = (mode == PWR_MAIN);
    assign v2b_stamp  = stamps[0];
    assign b2v_stamp  = stamps[1];
endmodule

// File: rtl/bkup_switch_chk.sv
module bkup_switch_chk #(
    parameter int VW       = 13,
    parameter int HYS_BAT  = 50,
    parameter int TRIP_MV  = 2200,
    parameter int HYS_TRIP = 30
) (
    input logic          clk,
    input logic          rst_n,
    input logic [VW-1:0] vdd_s,
    input logic [VW-1:0] vbat_s,
    input logic          lp_s,
    input logic [39:0]   now_time,
    input logic          wr_en,
    input logic          on_battery,
    input logic          bus_en,
    input logic [39:0]   v2b_stamp,
    input logic [39:0]   b2v_stamp
);
    a_r5_bus_off: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en == !on_battery);

    a_r2_entry_rule: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(on_battery) |->
            (32'($past(vdd_s)) + HYS_BAT < 32'($past(vbat_s))) &&
            ($past(lp_s) || 32'($past(vdd_s)) < TRIP_MV));

    a_r3_exit_rule: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(on_battery) |->
            (32'($past(vdd_s)) > 32'($past(vbat_s)) + HYS_BAT) ||
            (!$past(lp_s) && 32'($past(vdd_s)) > TRIP_MV + HYS_TRIP));

    a_r6_keep_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(on_battery) && !$past(wr_en)) |->
            (($past(v2b_stamp) == 40'd0) ? (v2b_stamp == $past(now_time))
                                         : (v2b_stamp == $past(v2b_stamp))));

    a_r7_latest: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(on_battery) |-> b2v_stamp == $past(now_time));

    a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (on_battery && $past(on_battery)) |->
            ($stable(v2b_stamp) && $stable(b2v_stamp)));
endmodule

bind bkup_switch_ctrl bkup_switch_chk #(
    .VW(VW), .HYS_BAT(HYS_BAT), .TRIP_MV(TRIP_MV), .HYS_TRIP(HYS_TRIP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .vdd_s(vdd_s), .vbat_s(vbat_s), .lp_s(lp_s),
    .now_time(now_time), .wr_en(wr_en), .on_battery(on_battery),
    .bus_en(bus_en), .v2b_stamp(v2b_stamp), .b2v_stamp(b2v_stamp)
);

// File: tb/sim_bkup_switch_ctrl.sv
module sim_bkup_switch_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] vdd_mv = 13'd3300, vbat_mv = 13'd3000;
    logic        low_pwr = 1'b0;
    logic [39:0] now_time = 40'h0;
    logic        wr_en = 1'b0, wr_bank = 1'b0;
    logic [2:0]  wr_idx = 3'd0;
    logic [7:0]  wr_data = 8'h00;
    logic        on_battery, bus_en;
    logic [39:0] v2b_stamp, b2v_stamp;
    int checks = 0, fails = 0;

    localparam logic [39:0] T1 = 40'h24_03_15_08_30;
    localparam logic [39:0] T2 = 40'h24_03_15_09_05;
    localparam logic [39:0] T3 = 40'h24_04_01_11_12;
    localparam logic [39:0] T4 = 40'h24_04_02_07_44;
    localparam logic [39:0] T5 = 40'h25_01_09_22_59;

    always #10 clk = ~clk;

    bkup_switch_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .vdd_mv(vdd_mv), .vbat_mv(vbat_mv),
        .low_pwr(low_pwr), .now_time(now_time), .wr_en(wr_en),
        .wr_bank(wr_bank), .wr_idx(wr_idx), .wr_data(wr_data),
        .on_battery(on_battery), .bus_en(bus_en),
        .v2b_stamp(v2b_stamp), .b2v_stamp(b2v_stamp)
    );

    task automatic chk(string req, logic [39:0] got, logic [39:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    function automatic bit m_enter(int vdd, int vbat, bit lp);
        return (vdd + 50 < vbat) && (lp || vdd < 2200);
    endfunction

    function automatic bit m_exit(int vdd, int vbat, bit lp);
        return (vdd > vbat + 50) || (!lp && vdd > 2230);
    endfunction

    task automatic apply(int vdd, int vbat, bit lp);
        @(negedge clk);
        vdd_mv = 13'(vdd); vbat_mv = 13'(vbat); low_pwr = lp;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(bit bank, int idx, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_bank = bank; wr_idx = 3'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int vb[7] = '{0, 1000, 2150, 2200, 2250, 3000, 4000};
        int off[6] = '{-51, -50, -49, 49, 50, 51};
        int fix[6] = '{2169, 2170, 2199, 2200, 2230, 2231};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 on_battery", 40'(on_battery), 40'd0);
        chk("R1 bus_en", 40'(bus_en), 40'd1);
        chk("R1 v2b", v2b_stamp, 40'd0);
        chk("R1 b2v", b2v_stamp, 40'd0);

        // R10 latency: one edge after the step, no change yet
        now_time = T1;
        @(negedge clk);
        vdd_mv = 13'd1000;
        @(posedge clk);
        @(negedge clk);
        chk("R10 one edge", 40'(on_battery), 40'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R10 two edges", 40'(on_battery), 40'd1);
        chk("R5 bus off", 40'(bus_en), 40'd0);
        chk("R6 first capture", v2b_stamp, T1);
        chk("R7 untouched", b2v_stamp, 40'd0);

        wr(1'b0, 0, 8'h00);
        chk("R9 write in backup", v2b_stamp, T1);

        now_time = T2;
        apply(3300, 3000, 0);
        chk("R7 return stamp", b2v_stamp, T2);
        chk("R5 bus on", 40'(bus_en), 40'd1);
        now_time = T3;
        apply(1000, 3000, 0);
        chk("R6 keep first", v2b_stamp, T1);
        now_time = T4;
        apply(3300, 3000, 0);
        chk("R7 overwrite", b2v_stamp, T4);

        wr(1'b0, 0, 8'h5A);
        chk("R8 nonzero ignored", v2b_stamp, T1);
        wr(1'b0, 5, 8'h00);
        chk("R8 index 5 ignored", v2b_stamp, T1);
        wr(1'b0, 0, 8'h00);
        chk("R8 byte0 cleared", v2b_stamp, T1 & ~40'hFF);
        for (int i = 1; i < 5; i++) wr(1'b0, i, 8'h00);
        chk("R8 bank cleared", v2b_stamp, 40'd0);
        wr(1'b1, 2, 8'h00);
        chk("R8 b2v byte2", b2v_stamp, T4 & ~40'hFF_0000);
        now_time = T5;
        apply(1000, 3000, 0);
        chk("R6 refill after clear", v2b_stamp, T5);
        apply(3300, 3000, 0);

        // R2/R3/R4 threshold sweeps
        for (int lp = 0; lp < 2; lp++) begin
            for (int a = 0; a < 7; a++) begin
                for (int k = 0; k < 12; k++) begin
                    int vd;
                    vd = (k < 6) ? vb[a] + off[k] : fix[k-6];
                    if (vd < 0) vd = 0;
                    apply(5000, vb[a], bit'(lp));
                    apply(vd, vb[a], bit'(lp));
                    chk(lp ? "R4 entry" : "R2 entry", 40'(on_battery),
                        40'(m_enter(vd, vb[a], bit'(lp))));
                    apply(0, 3000, bit'(lp));
                    apply(vd, vb[a], bit'(lp));
                    chk(lp ? "R4 exit" : "R3 exit", 40'(on_battery),
                        40'(!m_exit(vd, vb[a], bit'(lp))));
                    chk("R5 sweep", 40'(bus_en), 40'(!on_battery));
                end
            end
        end
        finish_run();
    end
endmodule